// File: doc/BRIEF.md
# Circular Return Address Predictor

This block predicts where a procedure return will go. Each call made by the fetch stream gives the block its return address, which is stored as the newest entry. When a return is fetched, the block offers the newest entry as the predicted target. That entry is then removed at the next clock edge. If no entry is held, the return gets no prediction.

Storage is a small ring of entries, three by default. A call made while the ring is full writes over the oldest entry, so the most recent call nesting is always kept. The block also gives a static direction guess for each call. A call with no condition is guessed taken, and a call that depends on a condition is guessed not taken. A flush input empties the ring when the pipeline discards its speculative path.

Top module: `callret_stack`

## Requirements
- R1: After a synchronous reset the ring holds no entries, so a return in the first cycle after reset gives `pred_valid_o` = 0.
- R2: A return in a cycle after one or more calls has `pred_valid_o` = 1 and `pred_addr_o` equal to the address of the most recent call that has not yet been popped. The order is last in, first out.
- R3: A return made while the ring is empty gives `pred_valid_o` = 0 and `pred_addr_o` = 0. The same outputs apply in any cycle with no return request.
- R4: A call made when DEPTH entries are held overwrites the oldest entry. After four calls A, B, C, D on a three-entry ring, successive returns predict D, C and B.
- R5: Occupancy saturates at DEPTH and never goes below zero. A fourth return after the D, C, B sequence, and any later return, gives no prediction until a new call is made.
- R6: A call and a return in the same cycle act as a pop followed by a push. In that cycle the prediction is the old newest entry. The call's address then replaces that entry, and occupancy stays the same. On an empty ring the pair acts as a single push.
- R7: `flush_i` empties the ring at the next edge and overrides any call or return in the same cycle. A return in the following cycle gives no prediction.
- R8: `call_taken_o` is 1 for a call with `call_cond_i` = 0 (unconditional) and 0 for a call with `call_cond_i` = 1 (conditional). It is also 0 when there is no call.
- R9: The prediction appears in the same cycle as the return request. The popped entry is gone from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Empty the ring at the next edge |
| call_valid_i | input | 1 | A procedure call is fetched this cycle |
| call_cond_i | input | 1 | The call depends on a condition |
| call_ret_addr_i | input | ADDR_W | Return address to push for the call |
| ret_valid_i | input | 1 | A procedure return asks for a prediction |
| pred_valid_o | output | 1 | A predicted return target is offered |
| pred_addr_o | output | ADDR_W | Predicted return target, 0 when not valid |
| call_taken_o | output | 1 | Static direction guess for the call |

## Verification
The ring is tested with shallow call and return nesting, which checks plain last-in-first-out order. It is also tested with bursts deeper than the ring, which shows whether the oldest entry is dropped instead of the newest and whether occupancy stops at three. Runs of returns on an empty ring show that occupancy cannot underflow. Same-cycle call and return pairs, on both empty and occupied rings, show the difference between the replace path and a separate pop and push. Flushes that coincide with calls and returns confirm that flush takes priority. Conditional and unconditional calls are mixed in throughout to check the direction guess.

// File: rtl/callret_pkg.sv
package callret_pkg;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_PUSH,
        OP_POP,
        OP_SWAP,
        OP_CLEAR
    } stk_op_e;

    typedef struct packed {
        logic valid;
        logic cond;
    } call_req_t;

    function automatic stk_op_e decode_op(logic flush, logic call, logic ret, logic empty);
        if (flush)              return OP_CLEAR;
        else if (call && ret)   return empty ? OP_PUSH : OP_SWAP;
        else if (call)          return OP_PUSH;
        else if (ret)           return empty ? OP_HOLD : OP_POP;
        else                    return OP_HOLD;
    endfunction

    function automatic int unsigned ring_fwd(int unsigned idx, int unsigned depth);
        return (idx + 1 >= depth) ? 0 : idx + 1;
    endfunction

    function automatic int unsigned ring_back(int unsigned idx, int unsigned depth);
        return (idx == 0) ? depth - 1 : idx - 1;
    endfunction

endpackage

// File: rtl/callret_track.sv
module callret_track
    import callret_pkg::*;
#(
    parameter int unsigned DEPTH = 3,
    parameter int unsigned IDX_W = 2,
    parameter int unsigned CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  stk_op_e          op,
    output logic [IDX_W-1:0] top_idx,
    output logic [IDX_W-1:0] wr_idx,
    output logic             wr_en,
    output logic [CNT_W-1:0] occ,
    output logic             empty
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [IDX_W-1:0] top_q, top_d;
    logic [CNT_W-1:0] occ_q, occ_d;
    logic [IDX_W-1:0] fwd_idx, back_idx;

    assign fwd_idx  = IDX_W'(ring_fwd(32'(top_q), DEPTH));
    assign back_idx = IDX_W'(ring_back(32'(top_q), DEPTH));

    always_comb begin
        top_d = top_q;
        occ_d = occ_q;
        unique case (op)
            OP_PUSH: begin
                top_d = fwd_idx;
                occ_d = (occ_q == FULL_CNT) ? FULL_CNT : occ_q + 1'b1;
            end
            OP_POP: begin
                top_d = back_idx;
                occ_d = occ_q - 1'b1;
            end
            OP_CLEAR: begin
                occ_d = '0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            top_q <= '0;
            occ_q <= '0;
        end else begin
            top_q <= top_d;
            occ_q <= occ_d;
        end
    end

    assign wr_en   = (op == OP_PUSH) || (op == OP_SWAP);
    assign wr_idx  = (op == OP_PUSH) ? fwd_idx : top_q;
    assign top_idx = top_q;
    assign occ     = occ_q;
    assign empty   = (occ_q == '0);

endmodule

// File: rtl/callret_store.sv
module callret_store #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DEPTH  = 3,
    parameter int unsigned IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_data
);

    logic [ADDR_W-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic hit;
        assign hit = wr_en && (wr_idx == IDX_W'(g));
        always_ff @(posedge clk) begin
            if (rst)      slot_q[g] <= '0;
            else if (hit) slot_q[g] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (rd_idx == IDX_W'(k)) rd_data = slot_q[k];
        end
    end

endmodule

// File: rtl/callret_dir.sv
module callret_dir
    import callret_pkg::*;
(
    input  call_req_t req,
    output logic      taken
);

    always_comb begin
        taken = 1'b0;
        if (req.valid) taken = !req.cond;
    end

endmodule

// File: rtl/callret_stack.sv
module callret_stack
    import callret_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DEPTH  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush_i,
    input  logic              call_valid_i,
    input  logic              call_cond_i,
    input  logic [ADDR_W-1:0] call_ret_addr_i,
    input  logic              ret_valid_i,
    output logic              pred_valid_o,
    output logic [ADDR_W-1:0] pred_addr_o,
    output logic              call_taken_o
);

    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    stk_op_e           op;
    logic [IDX_W-1:0]  top_idx, wr_idx;
    logic              wr_en, empty;
    logic [CNT_W-1:0]  occ_cnt;
    logic [ADDR_W-1:0] top_addr;
    call_req_t         call_req;

    assign op = decode_op(flush_i, call_valid_i, ret_valid_i, empty);

    callret_track #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_track (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .top_idx (top_idx),
        .wr_idx  (wr_idx),
        .wr_en   (wr_en),
        .occ     (occ_cnt),
        .empty   (empty)
    );

    callret_store #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (call_ret_addr_i),
        .rd_idx  (top_idx),
        .rd_data (top_addr)
    );

    assign call_req.valid = call_valid_i;
    assign call_req.cond  = call_cond_i;

    callret_dir u_dir (
        .req   (call_req),
        .taken (call_taken_o)
    );

    assign pred_valid_o = ret_valid_i && !empty;
    assign pred_addr_o  = pred_valid_o ? top_addr : '0;

endmodule

// File: rtl/callret_chk.sv
module callret_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DEPTH  = 3,
    parameter int unsigned CNT_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              flush_i,
    input logic              call_valid_i,
    input logic              call_cond_i,
    input logic [ADDR_W-1:0] call_ret_addr_i,
    input logic              ret_valid_i,
    input logic              pred_valid_o,
    input logic [ADDR_W-1:0] pred_addr_o,
    input logic              call_taken_o,
    input logic [CNT_W-1:0]  occ
);

    assert_reset_empty_R1: assert property (@(posedge clk)
        rst |=> (occ == '0));

    assert_push_then_predict_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(call_valid_i && !ret_valid_i && !flush_i) && ret_valid_i)
        |-> (pred_valid_o && pred_addr_o == $past(call_ret_addr_i)));

    assert_no_pred_addr_R3: assert property (@(posedge clk) disable iff (rst)
        !pred_valid_o |-> (pred_addr_o == '0));

    assert_count_bound_R5: assert property (@(posedge clk) disable iff (rst)
        occ <= CNT_W'(DEPTH));

    assert_saturate_R4: assert property (@(posedge clk) disable iff (rst)
        (occ == CNT_W'(DEPTH) && call_valid_i && !flush_i) |=> (occ == CNT_W'(DEPTH)));

    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
        (occ == '0 && ret_valid_i && !call_valid_i && !flush_i) |=> (occ == '0));

    assert_swap_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (occ != '0 && call_valid_i && ret_valid_i && !flush_i) |=> $stable(occ));

    assert_flush_clears_R7: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> (occ == '0));

    assert_cond_call_R8: assert property (@(posedge clk) disable iff (rst)
        (call_valid_i && call_cond_i) |-> !call_taken_o);

    assert_uncond_call_R8: assert property (@(posedge clk) disable iff (rst)
        (call_valid_i && !call_cond_i) |-> call_taken_o);

endmodule

bind callret_stack callret_chk #(
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH),
    .CNT_W  (CNT_W)
) u_chk (
    .clk             (clk),
    .rst             (rst),
    .flush_i         (flush_i),
    .call_valid_i    (call_valid_i),
    .call_cond_i     (call_cond_i),
    .call_ret_addr_i (call_ret_addr_i),
    .ret_valid_i     (ret_valid_i),
    .pred_valid_o    (pred_valid_o),
    .pred_addr_o     (pred_addr_o),
    .call_taken_o    (call_taken_o),
    .occ             (occ_cnt)
);

// File: tb/callret_stack_tb.sv
`timescale 1ns/1ps
module callret_stack_tb;

    localparam int unsigned ADDR_W = 32;
    localparam int unsigned DEPTH  = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              flush_i = 1'b0;
    logic              call_valid_i = 1'b0;
    logic              call_cond_i = 1'b0;
    logic [ADDR_W-1:0] call_ret_addr_i = '0;
    logic              ret_valid_i = 1'b0;
    logic              pred_valid_o;
    logic [ADDR_W-1:0] pred_addr_o;
    logic              call_taken_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [ADDR_W-1:0] mdl [DEPTH];
    int mn = 0;

    always #2.5 clk = ~clk;

    callret_stack #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_dut (
        .clk             (clk),
        .rst             (rst),
        .flush_i         (flush_i),
        .call_valid_i    (call_valid_i),
        .call_cond_i     (call_cond_i),
        .call_ret_addr_i (call_ret_addr_i),
        .ret_valid_i     (ret_valid_i),
        .pred_valid_o    (pred_valid_o),
        .pred_addr_o     (pred_addr_o),
        .call_taken_o    (call_taken_o)
    );

    function automatic logic exp_valid(logic ret);
        return ret && (mn > 0);
    endfunction

    function automatic logic [ADDR_W-1:0] exp_addr(logic ret);
        return (ret && mn > 0) ? mdl[mn-1] : '0;
    endfunction

    function automatic logic exp_taken(logic call, logic cond);
        return call && !cond;
    endfunction

    task automatic model_update(logic fl, logic call, logic [ADDR_W-1:0] a, logic ret);
        if (fl) begin
            mn = 0;
        end else if (call && ret && mn > 0) begin
            mdl[mn-1] = a;
        end else if (call) begin
            if (mn == DEPTH) begin
                for (int k = 0; k < DEPTH - 1; k++) mdl[k] = mdl[k+1];
                mdl[DEPTH-1] = a;
            end else begin
                mdl[mn] = a;
                mn++;
            end
        end else if (ret && mn > 0) begin
            mn--;
        end
    endtask

    task automatic check(string tag, string what, logic [ADDR_W-1:0] act, logic [ADDR_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag, logic fl, logic call, logic cond,
                        logic [ADDR_W-1:0] a, logic ret);
        @(negedge clk);
        flush_i = fl; call_valid_i = call; call_cond_i = cond;
        call_ret_addr_i = a; ret_valid_i = ret;
        #1;
        check(tag, "pred_valid", ADDR_W'(pred_valid_o), ADDR_W'(exp_valid(ret)));
        check(tag, "pred_addr", pred_addr_o, exp_addr(ret));
        check(tag, "call_taken", ADDR_W'(call_taken_o), ADDR_W'(exp_taken(call, cond)));
        model_update(fl, call, a, ret);
    endtask

    function automatic string rand_tag(logic fl, logic call, logic ret);
        if (fl)                      return "R7";
        if (call && ret)             return "R6";
        if (ret && mn == 0)          return "R3";
        if (call && mn == DEPTH)     return "R4";
        if (ret)                     return "R2";
        return "R8";
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: empty after reset
        step("R1", 0, 0, 0, '0, 1);
        // R2 / R9: push then predict in the same cycle as the return
        step("R2", 0, 1, 0, 32'h0000_1000, 0);
        step("R2", 0, 1, 1, 32'h0000_2000, 0);
        step("R9", 0, 0, 0, '0, 1);
        step("R2", 0, 0, 0, '0, 1);
        step("R3", 0, 0, 0, '0, 1);
        // R4: overflow drops oldest
        step("R4", 0, 1, 0, 32'hA, 0);
        step("R4", 0, 1, 0, 32'hB, 0);
        step("R4", 0, 1, 0, 32'hC, 0);
        step("R4", 0, 1, 0, 32'hD, 0);
        step("R4", 0, 0, 0, '0, 1);
        step("R4", 0, 0, 0, '0, 1);
        step("R4", 0, 0, 0, '0, 1);
        // R5: no underflow
        step("R5", 0, 0, 0, '0, 1);
        step("R5", 0, 0, 0, '0, 1);
        step("R5", 0, 1, 0, 32'hE, 0);
        step("R5", 0, 0, 0, '0, 1);
        // R6: simultaneous call and return
        step("R6", 0, 1, 1, 32'h11, 1);
        step("R6", 0, 1, 0, 32'h22, 0);
        step("R6", 0, 1, 0, 32'h33, 1);
        step("R6", 0, 0, 0, '0, 1);
        step("R6", 0, 0, 0, '0, 1);
        step("R6", 0, 0, 0, '0, 1);
        // R7: flush wins over call and return
        step("R7", 0, 1, 0, 32'h44, 0);
        step("R7", 1, 1, 0, 32'h55, 1);
        step("R7", 0, 0, 0, '0, 1);
        // R8: direction guess
        step("R8", 0, 1, 1, 32'h66, 0);
        step("R8", 0, 1, 0, 32'h77, 0);
        step("R8", 0, 0, 1, '0, 0);

        for (int i = 0; i < 3000; i++) begin
            logic fl, call, cond, ret;
            logic [ADDR_W-1:0] a;
            fl   = ($urandom % 20) == 0;
            call = ($urandom % 100) < 45;
            cond = $urandom % 2;
            ret  = ($urandom % 100) < 45;
            a    = $urandom;
            step(rand_tag(fl, call, ret), fl, call, cond, a, ret);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule